// File: doc/BRIEF.md
# MSI Doorbell to Interrupt Frame

This block is a small memory-mapped register frame that converts message-signalled interrupt writes into single-cycle pulses on a bank of wired interrupt lines. A bus master (typically a PCI host bridge) writes a global interrupt number into a doorbell register. The frame subtracts the global number of its first line, checks that the result falls inside its window, and pulses the matching output line for one clock.

The frame spans a 4 KB window with little-endian 32-bit registers. Besides the doorbell it offers a read-only type register that tells software which global numbers the frame owns, and an identification register. Accesses of an unsupported size and accesses to undefined offsets are dropped and reported on a one-cycle error flag. The frame's first line (`SPI_BASE`, counted from global number 32) and its line count (`LINE_COUNT`) are parameters. A configuration with more than 128 lines, or one that reaches past global number 1020, fails at elaboration.

All outputs are registered: the result of an access presented in cycle N appears in cycle N+1.

Top module: `msi_doorbell_frame`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `irq_lines` is all zero, `bus_err` is low and `rd_data` is zero.
- R2: A 32-bit read (`bus_size` = 2) of offset 0x008 returns, one cycle later, (SPI_BASE + 32) in bits [31:16] and LINE_COUNT in the low bits, with no error.
- R3: A 32-bit read of offset 0xFCC returns 0x051 in bits [31:20] and zero in all other bits, with no error.
- R4: A 32-bit read of any offset from 0xFD0 to 0xFFC returns zero with no error.
- R5: A 32-bit read of any other offset returns zero and raises `bus_err` for one cycle.
- R6: A read whose `bus_size` is not 2 (0 = byte, 1 = halfword, 2 = word, 3 = reserved) returns zero and raises `bus_err`.
- R7: A write of halfword or word size to offset 0x040 whose value g = `bus_wdata[9:0]` satisfies SPI_BASE + 32 <= g < SPI_BASE + 32 + LINE_COUNT drives line g - (SPI_BASE + 32) high for exactly the next cycle, with no error.
- R8: A doorbell write whose number falls below or above the frame's window pulses no line and raises no error.
- R9: A doorbell write of byte or reserved size pulses no line and raises `bus_err`.
- R10: A write to any offset other than 0x040 pulses no line and raises `bus_err`.
- R11: Bits [31:10] of the doorbell write value have no effect on which line is pulsed.
- R12: At most one line is high in any cycle, and two doorbell writes to the same line in consecutive cycles keep that line high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the 4 KB frame |
| bus_wdata | input | 32 | Write data |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 reserved |
| rd_data | output | 32 | Read data, valid the cycle after a read, zero otherwise |
| bus_err | output | 1 | One-cycle flag for a dropped access |
| irq_lines | output | LINE_COUNT | Interrupt line pulses |

## Verification
Every result of this block, whether read data, error flag or line pulse, is due exactly one clock after the cycle in which the access is presented, and in every other cycle the outputs return to zero. The bench drives each access on a falling edge, lets one rising edge register it, and compares all three outputs at the next falling edge; for back-to-back doorbell writes it compares the first result while presenting the second, so a pulse that is stretched, delayed or merged shows up as a mismatch.

// File: rtl/msi_frame_pkg.sv
package msi_frame_pkg;

    // Access size encoding on the register bus
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    // Register offsets inside the 4 KB frame
    localparam logic [11:0] OFF_TYPE     = 12'h008;
    localparam logic [11:0] OFF_DOORBELL = 12'h040;
    localparam logic [11:0] OFF_IDENT    = 12'hFCC;
    localparam logic [11:0] OFF_ZBLK_LO  = 12'hFD0;
    localparam logic [11:0] OFF_ZBLK_HI  = 12'hFFC;

    localparam int          GLOBAL_OFFSET = 32;
    localparam int          MAX_LINES     = 128;
    localparam int          GLOBAL_LIMIT  = 1020;
    localparam logic [11:0] PRODUCT_CODE  = 12'h051;

    // Decoded access class for one bus cycle
    typedef struct packed {
        logic ring;   // accepted doorbell write
        logic rd_ok;  // word-size read (data may still be zero)
        logic err;    // access dropped, flag raised
    } acc_decode_t;

endpackage

// File: rtl/msi_access_decode.sv
module msi_access_decode
    import msi_frame_pkg::*;
(
    input  logic        valid,
    input  logic        write,
    input  logic [11:0] addr,
    input  logic [1:0]  size,
    output acc_decode_t dec
);
    logic size_rd_ok;
    logic size_wr_ok;
    logic known_rd;
    logic is_bell;

    always_comb begin
        size_rd_ok = (size == SZ_WORD);
        size_wr_ok = (size == SZ_HALF) || (size == SZ_WORD);
        is_bell    = (addr == OFF_DOORBELL);
        known_rd   = (addr == OFF_TYPE) || (addr == OFF_IDENT) ||
                     ((addr >= OFF_ZBLK_LO) && (addr <= OFF_ZBLK_HI));

        dec.ring  = valid && write && is_bell && size_wr_ok;
        dec.rd_ok = valid && !write && size_rd_ok;
        if (!valid)
            dec.err = 1'b0;
        else if (write)
            dec.err = !(is_bell && size_wr_ok);
        else
            dec.err = !(size_rd_ok && known_rd);
    end
endmodule

// File: rtl/msi_read_mux.sv
module msi_read_mux
    import msi_frame_pkg::*;
#(
    parameter int SPI_BASE   = 16,
    parameter int LINE_COUNT = 64
) (
    input  logic [11:0] addr,
    input  logic        rd_ok,
    output logic [31:0] data
);
    localparam logic [15:0] FIRST_G    = 16'(SPI_BASE + GLOBAL_OFFSET);
    localparam logic [15:0] COUNT_W    = 16'(LINE_COUNT);
    localparam logic [31:0] TYPE_WORD  = {FIRST_G, COUNT_W};
    localparam logic [31:0] IDENT_WORD = {PRODUCT_CODE, 20'h0};

    always_comb begin
        data = 32'h0;
        if (rd_ok) begin
            case (addr)
                OFF_TYPE:  data = TYPE_WORD;
                OFF_IDENT: data = IDENT_WORD;
                default:   data = 32'h0;
            endcase
        end
    end
endmodule

// File: rtl/msi_line_map.sv
module msi_line_map
    import msi_frame_pkg::*;
#(
    parameter int SPI_BASE   = 16,
    parameter int LINE_COUNT = 64
) (
    input  logic                  ring,
    input  logic [9:0]            gnum,
    output logic [LINE_COUNT-1:0] hit
);
    // One comparator per line; numbers outside the window match none
    for (genvar i = 0; i < LINE_COUNT; i++) begin : g_line
        localparam logic [9:0] LINE_G = 10'(SPI_BASE + GLOBAL_OFFSET + i);
        assign hit[i] = ring && (gnum == LINE_G);
    end
endmodule

// File: rtl/msi_doorbell_frame.sv
module msi_doorbell_frame
    import msi_frame_pkg::*;
#(
    parameter int SPI_BASE   = 16,
    parameter int LINE_COUNT = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [11:0]           bus_addr,
    input  logic [31:0]           bus_wdata,
    input  logic [1:0]            bus_size,
    output logic [31:0]           rd_data,
    output logic                  bus_err,
    output logic [LINE_COUNT-1:0] irq_lines
);
    localparam bit CFG_OK = (LINE_COUNT >= 1) && (LINE_COUNT <= MAX_LINES) &&
                            (SPI_BASE >= 0) &&
                            (SPI_BASE + GLOBAL_OFFSET + LINE_COUNT <= GLOBAL_LIMIT);

    if (!CFG_OK) begin : g_cfg_bad
        $error("msi_doorbell_frame: line window exceeds the global number space");
    end

    typedef struct packed {
        logic [LINE_COUNT-1:0] irq;
        logic                  err;
        logic [31:0]           rdata;
    } frame_state_t;

    frame_state_t          st_d, st_q;
    acc_decode_t           dec;
    logic [31:0]           rd_word;
    logic [LINE_COUNT-1:0] hit;

    msi_access_decode u_dec (
        .valid (bus_valid),
        .write (bus_write),
        .addr  (bus_addr),
        .size  (bus_size),
        .dec   (dec)
    );

    msi_read_mux #(.SPI_BASE(SPI_BASE), .LINE_COUNT(LINE_COUNT)) u_rd (
        .addr  (bus_addr),
        .rd_ok (dec.rd_ok),
        .data  (rd_word)
    );

    msi_line_map #(.SPI_BASE(SPI_BASE), .LINE_COUNT(LINE_COUNT)) u_map (
        .ring  (dec.ring),
        .gnum  (bus_wdata[9:0]),
        .hit   (hit)
    );

    always_comb begin
        st_d       = '0;
        st_d.irq   = hit;
        st_d.err   = dec.err;
        st_d.rdata = rd_word;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign irq_lines = st_q.irq;
    assign bus_err   = st_q.err;
    assign rd_data   = st_q.rdata;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (irq_lines == '0 && !bus_err && rd_data == 32'h0));

    // R12
    single_line_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_lines));

    // R7
    pulse_source_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_lines != '0) |-> $past(bus_valid && bus_write && bus_addr == OFF_DOORBELL));

    // R7
    pulse_no_err_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_lines != '0) |-> !bus_err);

    // R6
    bad_read_size_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && bus_size != SZ_WORD) |=> (bus_err && rd_data == 32'h0));

    // R10
    bad_write_off_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && bus_addr != OFF_DOORBELL) |=> (bus_err && irq_lines == '0));

    // R9
    bad_write_size_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && (bus_size == SZ_BYTE || bus_size == SZ_RSVD))
        |=> (bus_err && irq_lines == '0));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |=> (irq_lines == '0 && !bus_err && rd_data == 32'h0));
endmodule

// File: tb/msi_doorbell_frame_tb_top.sv
module msi_doorbell_frame_tb_top;
    localparam int BASE  = 16;
    localparam int COUNT = 64;
    localparam int FIRST = BASE + 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_valid = 1'b0;
    logic             bus_write = 1'b0;
    logic [11:0]      bus_addr  = '0;
    logic [31:0]      bus_wdata = '0;
    logic [1:0]       bus_size  = '0;
    logic [31:0]      rd_data;
    logic             bus_err;
    logic [COUNT-1:0] irq_lines;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    msi_doorbell_frame #(.SPI_BASE(BASE), .LINE_COUNT(COUNT)) dut_i (
        .clk, .rst, .bus_valid, .bus_write, .bus_addr,
        .bus_wdata, .bus_size, .rd_data, .bus_err, .irq_lines
    );

    function automatic logic ring_ok(logic w, logic [11:0] a, logic [1:0] s);
        return w && a == 12'h040 && (s == 2'd1 || s == 2'd2);
    endfunction

    function automatic logic [COUNT-1:0] exp_irq(logic w, logic [11:0] a,
                                                 logic [31:0] d, logic [1:0] s);
        int g;
        g = int'(d[9:0]);
        if (ring_ok(w, a, s) && g >= FIRST && g < FIRST + COUNT)
            return {{(COUNT-1){1'b0}}, 1'b1} << (g - FIRST);
        return '0;
    endfunction

    function automatic logic exp_err(logic w, logic [11:0] a, logic [1:0] s);
        if (w) return !ring_ok(w, a, s);
        return !(s == 2'd2 && (a == 12'h008 || a == 12'hFCC ||
                               (a >= 12'hFD0 && a <= 12'hFFC)));
    endfunction

    function automatic logic [31:0] exp_rd(logic w, logic [11:0] a, logic [1:0] s);
        if (w || s != 2'd2) return 32'h0;
        if (a == 12'h008) return (32'(FIRST) << 16) | 32'(COUNT);
        if (a == 12'hFCC) return 32'h0510_0000;
        return 32'h0;
    endfunction

    task automatic check(string tag, logic [COUNT-1:0] ei, logic ee, logic [31:0] er);
        n_chk++;
        if (irq_lines !== ei || bus_err !== ee || rd_data !== er) begin
            n_fail++;
            $display("FAIL %s: irq=%h err=%b rd=%h expected irq=%h err=%b rd=%h",
                     tag, irq_lines, bus_err, rd_data, ei, ee, er);
        end
    endtask

    task automatic drive(logic w, logic [11:0] a, logic [31:0] d, logic [1:0] s);
        bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d; bus_size = s;
    endtask

    task automatic idle();
        bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0; bus_size = '0;
    endtask

    // Present one access, then compare its registered result one cycle later
    task automatic access(string tag, logic w, logic [11:0] a, logic [31:0] d, logic [1:0] s);
        @(negedge clk);
        drive(w, a, d, s);
        @(negedge clk);
        idle();
        check(tag, exp_irq(w, a, d, s), exp_err(w, a, s), exp_rd(w, a, s));
    endtask

    initial begin : watchdog
        #(200000 * 20);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        int seed;
        seed = 7;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        check("R1 during reset", '0, 1'b0, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", '0, 1'b0, 32'h0);

        access("R2 type register", 1'b0, 12'h008, 32'h0, 2'd2);
        access("R3 ident register", 1'b0, 12'hFCC, 32'h0, 2'd2);
        access("R4 zero block low", 1'b0, 12'hFD0, 32'h0, 2'd2);
        access("R4 zero block high", 1'b0, 12'hFFC, 32'h0, 2'd2);
        access("R5 undefined read", 1'b0, 12'h040, 32'h0, 2'd2);
        access("R5 undefined read 0xFC8", 1'b0, 12'hFC8, 32'h0, 2'd2);
        access("R6 halfword read", 1'b0, 12'h008, 32'h0, 2'd1);
        access("R6 byte read", 1'b0, 12'hFCC, 32'h0, 2'd0);
        access("R7 first line", 1'b1, 12'h040, 32'(FIRST), 2'd2);
        access("R7 last line", 1'b1, 12'h040, 32'(FIRST + COUNT - 1), 2'd1);
        access("R8 below window", 1'b1, 12'h040, 32'(FIRST - 1), 2'd2);
        access("R8 above window", 1'b1, 12'h040, 32'(FIRST + COUNT), 2'd2);
        access("R9 byte doorbell", 1'b1, 12'h040, 32'(FIRST + 3), 2'd0);
        access("R9 reserved size doorbell", 1'b1, 12'h040, 32'(FIRST + 3), 2'd3);
        access("R10 write to type", 1'b1, 12'h008, 32'(FIRST + 3), 2'd2);
        access("R11 upper bits ignored", 1'b1, 12'h040, 32'hFFFF_FC00 | 32'(FIRST + 5), 2'd2);

        // R12: consecutive writes to one line give two consecutive high cycles
        @(negedge clk);
        drive(1'b1, 12'h040, 32'(FIRST + 9), 2'd2);
        @(negedge clk);
        check("R12 first of pair", exp_irq(1'b1, 12'h040, 32'(FIRST + 9), 2'd2), 1'b0, 32'h0);
        @(negedge clk);
        idle();
        check("R12 second of pair", exp_irq(1'b1, 12'h040, 32'(FIRST + 9), 2'd2), 1'b0, 32'h0);
        @(negedge clk);
        check("R12 line drops after pair", '0, 1'b0, 32'h0);

        // Constrained random mix of doorbells and reads
        for (int i = 0; i < 400; i++) begin
            logic        w;
            logic [11:0] a;
            logic [31:0] d;
            logic [1:0]  s;
            w = $urandom_range(0, 1) == 1;
            s = 2'($urandom_range(0, 3));
            d = $urandom;
            if (w) begin
                a = ($urandom_range(0, 7) == 0) ? 12'($urandom_range(0, 4095)) : 12'h040;
                if ($urandom_range(0, 1) == 1)
                    d = {d[31:10], 10'(FIRST + $urandom_range(0, COUNT - 1))};
                access("R7 random doorbell", w, a, d, s);
            end else begin
                case ($urandom_range(0, 3))
                    0: a = 12'h008;
                    1: a = 12'hFCC;
                    2: a = 12'hFD0 + 12'(4 * $urandom_range(0, 11));
                    default: a = 12'($urandom_range(0, 4095));
                endcase
                access("R5 random read", w, a, d, s);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule